// File: doc/BRIEF.md
# Voltage-Compensated Fractional-N Divider Calculator

This block turns a rail voltage into the settings that a voltage-adaptive PLL needs. It produces a 7-bit detector gain, a detector calibration code, and a feedback divider split into an integer part and a sigma-delta word. A pulse on `start` captures all operands: a calibration voltage, an operating voltage, the detector ADC slope and offset, the effective divider `n_eff` and the delta ceiling `det_max`. The block then works through a fixed sequence of rounded signed divisions on one shared serial divider. It reports every result together with a one-cycle `valid` strobe.

The gain is computed as `round(round(cal_uv * -165230 / 10^6) + 214007) / 1000)` and clamped to the range 0..127. The calibration code is `round((cal_uv - adc_offs) / adc_slope)`. The detector delta is `round((op_uv - adc_offs) / adc_slope)` minus the calibration code, with an upper limit of `det_max`. The scaled divider is `n = n_eff*64 - gain*delta`. Its upper bits give the integer divider and its low six bits set the sigma-delta word. A value of `n` below zero or above `MAX_N*64` raises a range error. All divisions round half away from zero.

The controller steps through the states IDLE, PROD (voltage times gain slope, divided by 10^6), COEF (plus offset, divided by 1000, then clamped), CAL (calibration code), DET (operating code) and SPLIT (combine and publish). Each transition is listed below:
- IDLE to PROD on `start`.
- PROD to COEF, COEF to CAL, CAL to DET and DET to SPLIT, each when the divider signals done.
- SPLIT to IDLE unconditionally, raising `valid`.

Top module: `vfn_div_calc`

## Requirements
- R1: After reset `valid`, `busy`, `coeff`, `cal_code`, `n_int`, `sdm_word` and `range_err` are all zero.
- R2: A `start` seen while idle captures every operand and raises `busy` on the next cycle. While busy, `start` and operand changes are ignored: no second computation is launched and the result reflects the captured operands.
- R3: `valid` is high for exactly one cycle per computation, and `busy` has been high in the cycle before it. All outputs change only in a cycle where `valid` is high and hold their value otherwise.
- R4: `coeff` equals `round(round(cal_uv*(-165230)/1000000) + 214007) / 1000)`, rounding half away from zero. Negative results become 0 and results above 127 become 127.
- R5: `cal_code` equals `round((cal_uv - adc_offs)/adc_slope)` with half away from zero, as a 16-bit two's-complement value.
- R6: The detector delta `round((op_uv - adc_offs)/adc_slope) - cal_code` is limited from above to the signed value `det_max`. It is not limited from below.
- R7: With `n = n_eff*64 - coeff*delta` in range, `n_int` equals `n >> 6`.
- R8: With `n` in range, `sdm_word` equals bits [7:0] of `(((n mod 64)*128 - 4096) >>> 8)`. As a signed byte this value always lies in -16..15.
- R9: When `n < 0` or `n > MAX_N*64` (MAX_N = 255), `range_err` is 1 and both `n_int` and `sdm_word` are 0. `coeff` and `cal_code` are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin when idle |
| cal_uv | input | 32 | Calibration voltage in microvolts, signed |
| op_uv | input | 32 | Operating voltage in microvolts, signed |
| adc_slope | input | 32 | Detector ADC slope in microvolts per code, signed, nonzero |
| adc_offs | input | 32 | Detector ADC offset in microvolts, signed |
| n_eff | input | 8 | Effective feedback divider |
| det_max | input | 8 | Upper limit for the detector delta, signed |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle result strobe |
| coeff | output | 7 | Detector gain, clamped to 0..127 |
| cal_code | output | 16 | Calibration code, signed |
| n_int | output | 8 | Integer feedback divider |
| sdm_word | output | 8 | Sigma-delta input word |
| range_err | output | 1 | Scaled divider out of range |

## Verification
The main function is exercised by a sweep over six calibration voltages, five operating-voltage offsets, four delta ceilings and three effective dividers. The sweep includes ties on negative and positive numerators, which separate half-away rounding from truncation or half-up rounding. Calibration voltages at 0 and 2 V drive the gain into both clamp limits. Delta ceilings that are negative, zero and large separate the upper clamp from a two-sided clamp. Effective dividers of 8 and 255, paired with large deltas of either sign, push `n` past both range limits. A directed run changes the operands and pulses `start` in the middle of a computation, which separates true operand capture from live sampling.

// File: rtl/vfn_pkg.sv
package vfn_pkg;

    // Controller states, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROD,
        ST_COEF,
        ST_CAL,
        ST_DET,
        ST_SPLIT
    } calc_state_t;

    // Gain law: gain = (slope * uv / 1e6 + offset) / 1000.
    localparam int GAIN_SLOPE  = -165230;
    localparam int GAIN_OFFSET = 214007;
    localparam int PROD_DEN    = 1000000;
    localparam int GAIN_DEN    = 1000;

    localparam int COEF_W      = 7;
    localparam int COEF_MAX    = (1 << COEF_W) - 1;

    // Fixed-point split of the scaled feedback divider.
    localparam int FRAC_BITS   = 6;
    localparam int SDM_RANGE   = 12;
    localparam int SDM_SHIFT   = 8;

endpackage

// File: rtl/vfn_rdiv.sv
// Serial signed divider with round-half-away-from-zero quotient.
// Works on magnitudes: q = (|a| + |b|/2) / |b|, and the sign is applied afterwards.
module vfn_rdiv #(
    parameter int W = 56
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                done,
    output logic signed [W-1:0] quo
);
    localparam int UW = W + 1;
    localparam int CW = $clog2(UW + 1);

    logic [UW-1:0] dvd_q;
    logic [UW-1:0] dsr_q;
    logic [UW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          neg_q;
    logic          run_q;
    logic          done_q;

    logic [UW-1:0] num_x, den_x, a_mag, b_mag;
    logic [UW:0]   trial;
    logic          fits;
    logic [W-1:0]  mag;

    always_comb begin
        num_x = {num[W-1], num};
        den_x = {den[W-1], den};
        a_mag = num[W-1] ? (~num_x + 1'b1) : num_x;
        b_mag = den[W-1] ? (~den_x + 1'b1) : den_x;
        trial = {rem_q, dvd_q[UW-1]};
        fits  = (trial >= {1'b0, dsr_q});
        mag   = dvd_q[W-1:0];
        quo   = neg_q ? $signed(~mag + 1'b1) : $signed(mag);
        done  = done_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            dsr_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            neg_q  <= 1'b0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                dvd_q <= a_mag + {1'b0, b_mag[UW-1:1]};
                dsr_q <= b_mag;
                rem_q <= '0;
                cnt_q <= CW'(UW);
                neg_q <= num[W-1] ^ den[W-1];
                run_q <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    rem_q <= UW'(trial - {1'b0, dsr_q});
                end else begin
                    rem_q <= trial[UW-1:0];
                end
                dvd_q <= {dvd_q[UW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vfn_ndiv_split.sv
// Combines the detector codes into the scaled divider and splits it into
// an integer part and a sigma-delta word. Purely combinational.
module vfn_ndiv_split import vfn_pkg::*; #(
    parameter int DIVW  = 56,
    parameter int N_W   = 8,
    parameter int MAX_N = 255,
    parameter int DM_W  = 8,
    parameter int SDM_W = 8
) (
    input  logic [N_W-1:0]          n_eff,
    input  logic [COEF_W-1:0]       coeff,
    input  logic signed [DIVW-1:0]  q_cal,
    input  logic signed [DIVW-1:0]  q_op,
    input  logic signed [DM_W-1:0]  det_max,
    output logic [N_W-1:0]          n_int,
    output logic [SDM_W-1:0]        sdm,
    output logic                    err
);
    localparam int PW = DIVW + COEF_W + 4;
    localparam int SW = SDM_RANGE + 2;
    localparam logic signed [PW-1:0] N_LIMIT = PW'(MAX_N) <<< FRAC_BITS;

    logic signed [PW-1:0] delta, dmx, dcl, gain_x, scaled, base, n_full;
    logic [FRAC_BITS-1:0] rem;
    logic signed [SW-1:0] sdm_full, sdm_sh;

    always_comb begin
        delta  = PW'(q_op) - PW'(q_cal);
        dmx    = PW'(det_max);
        dcl    = (delta > dmx) ? dmx : delta;
        gain_x = $signed(PW'(coeff));
        scaled = dcl * gain_x;
        base   = $signed(PW'(n_eff)) <<< FRAC_BITS;
        n_full = base - scaled;
        err    = (n_full < 0) || (n_full > N_LIMIT);
        rem    = n_full[FRAC_BITS-1:0];
        sdm_full = $signed({1'b0, rem, {(SDM_RANGE + 1 - FRAC_BITS){1'b0}}})
                   - $signed(SW'(1 << SDM_RANGE));
        sdm_sh = sdm_full >>> SDM_SHIFT;
        n_int  = err ? '0 : n_full[FRAC_BITS+N_W-1:FRAC_BITS];
        sdm    = err ? '0 : sdm_sh[SDM_W-1:0];
    end

endmodule

// File: rtl/vfn_div_calc.sv
module vfn_div_calc import vfn_pkg::*; #(
    parameter int UV_W  = 32,
    parameter int N_W   = 8,
    parameter int MAX_N = 255,
    parameter int DM_W  = 8,
    parameter int CAL_W = 16,
    parameter int SDM_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [UV_W-1:0]  cal_uv,
    input  logic signed [UV_W-1:0]  op_uv,
    input  logic signed [UV_W-1:0]  adc_slope,
    input  logic signed [UV_W-1:0]  adc_offs,
    input  logic [N_W-1:0]          n_eff,
    input  logic signed [DM_W-1:0]  det_max,
    output logic                    busy,
    output logic                    valid,
    output logic [COEF_W-1:0]       coeff,
    output logic signed [CAL_W-1:0] cal_code,
    output logic [N_W-1:0]          n_int,
    output logic [SDM_W-1:0]        sdm_word,
    output logic                    range_err
);
    localparam int DIVW = UV_W + 24;
    localparam logic signed [DIVW-1:0] SLOPE_X = DIVW'(GAIN_SLOPE);
    localparam logic signed [DIVW-1:0] OFFS_X  = DIVW'(GAIN_OFFSET);
    localparam logic signed [DIVW-1:0] PDEN_X  = DIVW'(PROD_DEN);
    localparam logic signed [DIVW-1:0] GDEN_X  = DIVW'(GAIN_DEN);
    localparam logic signed [DIVW-1:0] CMAX_X  = DIVW'(COEF_MAX);

    calc_state_t state_q, state_d;

    // captured operands
    logic signed [UV_W-1:0] uvc_q, uvo_q, slope_q, offs_q;
    logic [N_W-1:0]         neff_q;
    logic signed [DM_W-1:0] dmax_q;

    // staged results
    logic signed [DIVW-1:0] prod_q, qcal_q, qop_q;
    logic [COEF_W-1:0]      coef_q;

    logic                   launch_q;
    logic signed [DIVW-1:0] div_num, div_den, div_quo;
    logic                   div_done;
    logic signed [DIVW-1:0] uvc_x, uvo_x, slope_x, offs_x;

    logic [N_W-1:0]   sp_nint;
    logic [SDM_W-1:0] sp_sdm;
    logic             sp_err;

    assign busy = (state_q != ST_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            launch_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            launch_q <= (state_d != state_q) &&
                        (state_d inside {ST_PROD, ST_COEF, ST_CAL, ST_DET});
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_PROD;
            ST_PROD:  if (div_done) state_d = ST_COEF;
            ST_COEF:  if (div_done) state_d = ST_CAL;
            ST_CAL:   if (div_done) state_d = ST_DET;
            ST_DET:   if (div_done) state_d = ST_SPLIT;
            ST_SPLIT:               state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // ---------------- divider operand selection ----------------
    always_comb begin
        uvc_x   = {{(DIVW-UV_W){uvc_q[UV_W-1]}},   uvc_q};
        uvo_x   = {{(DIVW-UV_W){uvo_q[UV_W-1]}},   uvo_q};
        slope_x = {{(DIVW-UV_W){slope_q[UV_W-1]}}, slope_q};
        offs_x  = {{(DIVW-UV_W){offs_q[UV_W-1]}},  offs_q};
        div_num = '0;
        div_den = DIVW'(1);
        unique case (state_q)
            ST_PROD: begin div_num = uvc_x * SLOPE_X;  div_den = PDEN_X;  end
            ST_COEF: begin div_num = prod_q + OFFS_X;  div_den = GDEN_X;  end
            ST_CAL:  begin div_num = uvc_x - offs_x;   div_den = slope_x; end
            ST_DET:  begin div_num = uvo_x - offs_x;   div_den = slope_x; end
            default: begin div_num = '0;               div_den = DIVW'(1); end
        endcase
    end

    vfn_rdiv #(.W(DIVW)) i_rdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (launch_q),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    // ---------------- capture and staging ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uvc_q   <= '0;
            uvo_q   <= '0;
            slope_q <= '0;
            offs_q  <= '0;
            neff_q  <= '0;
            dmax_q  <= '0;
            prod_q  <= '0;
            qcal_q  <= '0;
            qop_q   <= '0;
            coef_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                uvc_q   <= cal_uv;
                uvo_q   <= op_uv;
                slope_q <= adc_slope;
                offs_q  <= adc_offs;
                neff_q  <= n_eff;
                dmax_q  <= det_max;
            end
            if (div_done) begin
                unique case (state_q)
                    ST_PROD: prod_q <= div_quo;
                    ST_COEF: begin
                        if (div_quo < 0)           coef_q <= '0;
                        else if (div_quo > CMAX_X) coef_q <= COEF_W'(COEF_MAX);
                        else                       coef_q <= div_quo[COEF_W-1:0];
                    end
                    ST_CAL:  qcal_q <= div_quo;
                    ST_DET:  qop_q  <= div_quo;
                    default: ;
                endcase
            end
        end
    end

    vfn_ndiv_split #(
        .DIVW (DIVW),
        .N_W  (N_W),
        .MAX_N(MAX_N),
        .DM_W (DM_W),
        .SDM_W(SDM_W)
    ) i_split (
        .n_eff  (neff_q),
        .coeff  (coef_q),
        .q_cal  (qcal_q),
        .q_op   (qop_q),
        .det_max(dmax_q),
        .n_int  (sp_nint),
        .sdm    (sp_sdm),
        .err    (sp_err)
    );

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            coeff     <= '0;
            cal_code  <= '0;
            n_int     <= '0;
            sdm_word  <= '0;
            range_err <= 1'b0;
        end else begin
            valid <= (state_q == ST_SPLIT);
            if (state_q == ST_SPLIT) begin
                coeff     <= coef_q;
                cal_code  <= qcal_q[CAL_W-1:0];
                n_int     <= sp_nint;
                sdm_word  <= sp_sdm;
                range_err <= sp_err;
            end
        end
    end

endmodule

// File: rtl/vfn_div_calc_chk.sv
module vfn_div_calc_chk #(
    parameter int N_W   = 8,
    parameter int CAL_W = 16,
    parameter int SDM_W = 8,
    parameter int CF_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             valid,
    input logic [CF_W-1:0]  coeff,
    input logic [CAL_W-1:0] cal_code,
    input logic [N_W-1:0]   n_int,
    input logic [SDM_W-1:0] sdm_word,
    input logic             range_err
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_valid_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(busy));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(coeff) && $stable(cal_code) && $stable(n_int)
                    && $stable(sdm_word) && $stable(range_err)));

    assert_sdm_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !range_err) |-> (($signed(sdm_word) >= -16) && ($signed(sdm_word) <= 15)));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && range_err) |-> (n_int == '0 && sdm_word == '0));

endmodule

bind vfn_div_calc vfn_div_calc_chk #(
    .N_W  (N_W),
    .CAL_W(CAL_W),
    .SDM_W(SDM_W),
    .CF_W (vfn_pkg::COEF_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .valid    (valid),
    .coeff    (coeff),
    .cal_code (cal_code),
    .n_int    (n_int),
    .sdm_word (sdm_word),
    .range_err(range_err)
);

// File: tb/test_vfn_div_calc.sv
`timescale 1ns/1ps
module test_vfn_div_calc;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic signed [31:0] cal_uv = '0, op_uv = '0, adc_slope = '0, adc_offs = '0;
    logic [7:0]         n_eff = '0;
    logic signed [7:0]  det_max = '0;
    logic               busy, valid, range_err;
    logic [6:0]         coeff;
    logic signed [15:0] cal_code;
    logic [7:0]         n_int, sdm_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    vfn_div_calc i_vfn_div_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cal_uv(cal_uv), .op_uv(op_uv), .adc_slope(adc_slope), .adc_offs(adc_offs),
        .n_eff(n_eff), .det_max(det_max),
        .busy(busy), .valid(valid), .coeff(coeff), .cal_code(cal_code),
        .n_int(n_int), .sdm_word(sdm_word), .range_err(range_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic longint rdiv(longint a, longint b);
        longint aa = (a < 0) ? -a : a;
        longint bb = (b < 0) ? -b : b;
        longint q  = (aa + bb / 2) / bb;
        return ((a < 0) != (b < 0)) ? -q : q;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model(input longint uvc, input longint uvo, input longint slope,
                         input longint offs, input longint ne, input longint dm,
                         output longint e_cf, output longint e_cal, output longint e_ni,
                         output longint e_sdm, output longint e_err);
        longint p, c, qc, qo, d, n;
        p = rdiv(uvc * -165230, 1000000);
        c = rdiv(p + 214007, 1000);
        if (c < 0) c = 0;
        if (c > 127) c = 127;
        qc = rdiv(uvc - offs, slope);
        qo = rdiv(uvo - offs, slope);
        d  = qo - qc;
        if (d > dm) d = dm;
        n  = ne * 64 - d * c;
        e_cf  = c;
        e_cal = qc;
        e_err = (n < 0 || n > 255 * 64) ? 1 : 0;
        if (e_err != 0) begin
            e_ni = 0;
            e_sdm = 0;
        end else begin
            e_ni  = n >>> 6;
            e_sdm = ((((n & 63) * 128) - 4096) >>> 8) & 255;
        end
    endtask

    task automatic launch(input longint uvc, input longint uvo, input longint slope,
                          input longint offs, input longint ne, input longint dm);
        @(negedge clk);
        cal_uv = 32'(uvc); op_uv = 32'(uvo); adc_slope = 32'(slope); adc_offs = 32'(offs);
        n_eff = 8'(ne); det_max = 8'(dm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    endtask

    task automatic wait_valid();
        int guard = 0;
        while (!valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic compare(input longint uvc, input longint uvo, input longint slope,
                           input longint offs, input longint ne, input longint dm);
        longint e_cf, e_cal, e_ni, e_sdm, e_err;
        model(uvc, uvo, slope, offs, ne, dm, e_cf, e_cal, e_ni, e_sdm, e_err);
        check(valid == 1'b1, "R3 valid strobe", longint'(valid), 1);
        check(longint'(coeff) == e_cf, "R4 coeff", longint'(coeff), e_cf);
        check(longint'(cal_code) == e_cal, "R5 cal_code", longint'(cal_code), e_cal);
        check(longint'(range_err) == e_err, "R9 range_err", longint'(range_err), e_err);
        check(longint'(n_int) == e_ni, "R6 R7 n_int", longint'(n_int), e_ni);
        check(longint'(sdm_word) == e_sdm, "R8 sdm_word", longint'(sdm_word), e_sdm);
        @(negedge clk);
        check(valid == 1'b0, "R3 valid one cycle", longint'(valid), 0);
    endtask

    longint uvc_set[6] = '{0, 700000, 850000, 1000000, 1150000, 2000000};
    longint dv_set[5]  = '{-55000, -20000, 0, 5000, 95000};
    longint dm_set[4]  = '{-3, 0, 4, 100};
    longint ne_set[3]  = '{8, 100, 255};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(valid == 1'b0 && busy == 1'b0, "R1 valid/busy", longint'({valid, busy}), 0);
        check(coeff == '0 && cal_code == '0, "R1 coeff/cal", longint'(coeff), 0);
        check(n_int == '0 && sdm_word == '0 && range_err == 1'b0, "R1 divider outputs",
              longint'(n_int), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: operands and start changed mid-run are ignored
        launch(850000, 855000, 10000, 600000, 100, 4);
        repeat (20) @(negedge clk);
        cal_uv = 32'sd2000000; op_uv = 32'sd100000; adc_slope = 32'sd7000;
        adc_offs = 32'sd5; n_eff = 8'd3; det_max = -8'sd50;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        compare(850000, 855000, 10000, 600000, 100, 4);
        check(busy == 1'b0, "R2 idle after result", longint'(busy), 0);
        begin
            int extra = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (valid || busy) extra++;
            end
            check(extra == 0, "R2 no second run", extra, 0);
        end

        // negative slope, negative offset
        launch(900000, 870000, -12500, -50000, 60, 10);
        wait_valid();
        compare(900000, 870000, -12500, -50000, 60, 10);

        // main sweep
        foreach (uvc_set[a])
            foreach (dv_set[b])
                foreach (dm_set[c])
                    foreach (ne_set[d]) begin
                        launch(uvc_set[a], uvc_set[a] + dv_set[b], 10000, 600000,
                               ne_set[d], dm_set[c]);
                        wait_valid();
                        compare(uvc_set[a], uvc_set[a] + dv_set[b], 10000, 600000,
                                ne_set[d], dm_set[c]);
                    end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule